// File: doc/BRIEF.md
# Link Equalization Handshake Controller

This controller sequences the two-phase transmitter/receiver equalization negotiation between two link partners over a simplified message interface. In each phase, one side is the requester and the other is the responder. The requester asks for a transmit setting, given either as a preset index or as an explicit pre/main/post coefficient triple. The responder checks the request, loads it into its transmit filter register and sends back a confirmation that echoes the applied setting. Only after a matching confirmation does the requester start its local receiver tuning, which is modelled as a start pulse and a done pulse.

The request, confirm and tune loop runs a configurable number of times. The requester then sends a final acknowledge, and both sides enter the second phase with the roles swapped. In the first phase the endpoint requests and the root responds; in the second phase the root requests. A wrong echo, a missing message or an out-of-range request aborts the sequence with a sticky error flag. Completing the second phase raises a sticky done flag. Both flags are cleared by the next start.

One instance sits on each side of the link. The `isRoot` input tells the instance which role it has in each phase.

Top module: `lnkeq_hs_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the controller idle, with `txValid`, `tuneStart`, `eqDone`, `eqError` and the whole filter register at zero.
- R2: A start in idle begins phase 1. In phase 1 the side with `isRoot`=0 is the requester and the side with `isRoot`=1 only responds. In phase 2 the roles are reversed. A responder emits nothing until it receives a request.
- R3: Message kinds are encoded on 2 bits: 1 = request, 2 = confirmation, 3 = final acknowledge. A request carries the local setting sampled when it is sent: the preset flag, the 4-bit preset and three 6-bit coefficients (pre, main, post).
- R4: A responder that receives a valid request loads every field into its filter outputs. Two cycles after the request cycle, it emits a confirmation carrying the filter contents.
- R5: The requester pulses `tuneStart` for exactly one cycle, one cycle after a confirmation whose fields all equal the request. It never pulses `tuneStart` before that confirmation.
- R6: A confirmation whose fields differ from the request sets `eqError`, returns the controller to idle and produces no `tuneStart`.
- R7: If the awaited confirmation (as requester) or request/acknowledge (as responder) does not arrive within `cfgTimeout` cycles (0 counts as 1), `eqError` is set and the controller returns to idle.
- R8: A request is invalid if it is in coefficient form with pre+main+post greater than `cfgFullSwing`, or in preset form with a preset above 10. An invalid request sets `eqError`, leaves the filter unchanged and is not confirmed. A sum equal to `cfgFullSwing` is accepted.
- R9: The requester performs `cfgIters` request/confirm/tune rounds (0 counts as 1). It then sends one final acknowledge, whose payload fields are all zero.
- R10: The final acknowledge moves both sides to phase 2. When phase 2 ends with its acknowledge, `eqDone` is set.
- R11: `eqDone` and `eqError` stay set until the next start clears them, and they are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin equalization (taken in idle only) |
| isRoot | input | 1 | 1 = this side is the root, 0 = endpoint |
| cfgIters | input | ITER_W | Rounds per phase |
| cfgTimeout | input | TMO_W | Message wait limit in cycles |
| cfgFullSwing | input | 8 | Maximum coefficient sum |
| locUsePreset | input | 1 | Local request uses a preset |
| locPreset | input | 4 | Local requested preset |
| locPre | input | 6 | Local requested pre-cursor |
| locMain | input | 6 | Local requested main cursor |
| locPost | input | 6 | Local requested post-cursor |
| rxValid | input | 1 | Incoming message strobe |
| rxKind | input | 2 | Incoming message kind |
| rxUsePreset | input | 1 | Incoming preset flag |
| rxPreset | input | 4 | Incoming preset |
| rxPre | input | 6 | Incoming pre-cursor |
| rxMain | input | 6 | Incoming main cursor |
| rxPost | input | 6 | Incoming post-cursor |
| txValid | output | 1 | Outgoing message strobe |
| txKind | output | 2 | Outgoing message kind |
| txUsePreset | output | 1 | Outgoing preset flag |
| txPreset | output | 4 | Outgoing preset |
| txPre | output | 6 | Outgoing pre-cursor |
| txMain | output | 6 | Outgoing main cursor |
| txPost | output | 6 | Outgoing post-cursor |
| tuneStart | output | 1 | Start local receiver tuning |
| tuneDone | input | 1 | Local receiver tuning finished |
| filtUsePreset | output | 1 | Applied transmit filter: preset flag |
| filtPreset | output | 4 | Applied transmit filter: preset |
| filtPre | output | 6 | Applied transmit filter: pre-cursor |
| filtMain | output | 6 | Applied transmit filter: main cursor |
| filtPost | output | 6 | Applied transmit filter: post-cursor |
| eqDone | output | 1 | Equalization complete (sticky) |
| eqError | output | 1 | Equalization aborted (sticky) |

## Verification
A wrong state in this controller shows at the ports within a cycle or two. A lost role swap makes a side emit a request it should not, or stay silent when one is due. A wrong iteration count shifts the final acknowledge by a whole round. A wrong comparison either pulses `tuneStart` after a bad echo or raises `eqError` after a good one. The bench acts as the link partner and the receiver tuner. It predicts every outgoing message in order and compares the filter outputs and flags at fixed cycle offsets after each stimulus. These offsets include the timeout boundary and the full-swing boundary.

// File: rtl/lnkeq_pkg.sv
package lnkeq_pkg;
  localparam int COEF_W   = 6;
  localparam int PRESET_W = 4;
  localparam int SUM_W    = COEF_W + 2;

  typedef enum logic [1:0] {
    MSG_NONE = 2'd0,
    MSG_REQ  = 2'd1,
    MSG_CONF = 2'd2,
    MSG_ACK  = 2'd3
  } msgKind_e;

  typedef struct packed {
    logic                usePreset;
    logic [PRESET_W-1:0] preset;
    logic [COEF_W-1:0]   pre;
    logic [COEF_W-1:0]   main;
    logic [COEF_W-1:0]   post;
  } eqSet_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SEND_REQ, ST_WAIT_CONF, ST_RX_TUNE, ST_FINAL_ACK,
    ST_PHASE_SWITCH, ST_WAIT_REQ, ST_SEND_CONF, ST_DONE, ST_ERROR
  } eqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sendReq;
    logic sendConf;
    logic sendAck;
    logic loadFilt;
    logic startTune;
    logic clrIter;
    logic incIter;
    logic clrWait;
    logic incWait;
    logic clrPhase;
    logic setPhase2;
    logic clrFlags;
    logic setDone;
    logic setErr;
  } ctrlStb_t;

  // status from datapath to control
  typedef struct packed {
    logic echoMatch;
    logic reqOk;
    logic lastIter;
    logic waitExpired;
    logic phase2;
  } dpStat_t;
endpackage

// File: rtl/lnkeq_datapath.sv
module lnkeq_datapath
  import lnkeq_pkg::*;
#(
  parameter int ITER_W     = 8,
  parameter int TMO_W      = 16,
  parameter int MAX_PRESET = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStb_t          stb,
  input  logic [ITER_W-1:0] cfgIters,
  input  logic [TMO_W-1:0]  cfgTimeout,
  input  logic [SUM_W-1:0]  cfgFullSwing,
  input  eqSet_t            locSet,
  input  eqSet_t            rxSet,
  output dpStat_t           stat,
  output logic              txValid,
  output logic [1:0]        txKind,
  output eqSet_t            txSet,
  output logic              tuneStart,
  output eqSet_t            filtSet,
  output logic              eqDone,
  output logic              eqError
);
  eqSet_t            reqQ;
  logic [ITER_W-1:0] iterQ;
  logic [TMO_W-1:0]  waitQ;
  logic              phase2Q;

  logic [ITER_W-1:0] itersEff;
  logic [TMO_W-1:0]  tmoEff;
  logic [ITER_W:0]   iterNext;
  logic [SUM_W-1:0]  coefSum;

  assign itersEff = (cfgIters == '0) ? ITER_W'(1) : cfgIters;
  assign tmoEff   = (cfgTimeout == '0) ? TMO_W'(1) : cfgTimeout;
  assign iterNext = {1'b0, iterQ} + (ITER_W+1)'(1);
  assign coefSum  = SUM_W'(rxSet.pre) + SUM_W'(rxSet.main) + SUM_W'(rxSet.post);

  assign stat.reqOk       = rxSet.usePreset ? (rxSet.preset <= PRESET_W'(MAX_PRESET))
                                            : (coefSum <= cfgFullSwing);
  assign stat.echoMatch   = (rxSet == reqQ);
  assign stat.lastIter    = (iterNext >= {1'b0, itersEff});
  assign stat.waitExpired = (waitQ >= (tmoEff - TMO_W'(1)));
  assign stat.phase2      = phase2Q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reqQ      <= '0;
      filtSet   <= '0;
      txSet     <= '0;
      txKind    <= MSG_NONE;
      txValid   <= 1'b0;
      tuneStart <= 1'b0;
      iterQ     <= '0;
      waitQ     <= '0;
      phase2Q   <= 1'b0;
      eqDone    <= 1'b0;
      eqError   <= 1'b0;
    end else begin
      txValid   <= stb.sendReq | stb.sendConf | stb.sendAck;
      tuneStart <= stb.startTune;
      if (stb.sendReq) begin
        reqQ   <= locSet;
        txSet  <= locSet;
        txKind <= MSG_REQ;
      end else if (stb.sendConf) begin
        txSet  <= filtSet;
        txKind <= MSG_CONF;
      end else if (stb.sendAck) begin
        txSet  <= '0;
        txKind <= MSG_ACK;
      end else begin
        txSet  <= '0;
        txKind <= MSG_NONE;
      end
      if (stb.loadFilt) filtSet <= rxSet;
      if (stb.clrIter)      iterQ <= '0;
      else if (stb.incIter) iterQ <= iterQ + ITER_W'(1);
      if (stb.clrWait)      waitQ <= '0;
      else if (stb.incWait) waitQ <= waitQ + TMO_W'(1);
      if (stb.clrPhase)       phase2Q <= 1'b0;
      else if (stb.setPhase2) phase2Q <= 1'b1;
      if (stb.clrFlags) begin
        eqDone  <= 1'b0;
        eqError <= 1'b0;
      end else begin
        if (stb.setDone) eqDone  <= 1'b1;
        if (stb.setErr)  eqError <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lnkeq_ctrl.sv
module lnkeq_ctrl
  import lnkeq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       isRoot,
  input  logic       rxValid,
  input  logic [1:0] rxKind,
  input  logic       tuneDone,
  input  dpStat_t    stat,
  output ctrlStb_t   stb
);
  eqState_e stateQ, stateD;

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (start) begin
        stb.clrFlags = 1'b1;
        stb.clrIter  = 1'b1;
        stb.clrWait  = 1'b1;
        stb.clrPhase = 1'b1;
        stateD = isRoot ? ST_WAIT_REQ : ST_SEND_REQ;  // endpoint asks first
      end
      ST_SEND_REQ: begin
        stb.sendReq = 1'b1;
        stb.clrWait = 1'b1;
        stateD = ST_WAIT_CONF;
      end
      ST_WAIT_CONF: begin
        if (rxValid && rxKind == MSG_CONF) begin
          if (stat.echoMatch) begin
            stb.startTune = 1'b1;
            stateD = ST_RX_TUNE;
          end else begin
            stateD = ST_ERROR;
          end
        end else if (stat.waitExpired) begin
          stateD = ST_ERROR;
        end else begin
          stb.incWait = 1'b1;
        end
      end
      ST_RX_TUNE: if (tuneDone) begin
        stb.incIter = 1'b1;
        stateD = stat.lastIter ? ST_FINAL_ACK : ST_SEND_REQ;
      end
      ST_FINAL_ACK: begin
        stb.sendAck = 1'b1;
        stateD = ST_PHASE_SWITCH;
      end
      ST_PHASE_SWITCH: begin
        if (stat.phase2) begin
          stateD = ST_DONE;
        end else begin
          stb.setPhase2 = 1'b1;
          stb.clrIter   = 1'b1;
          stb.clrWait   = 1'b1;
          stateD = isRoot ? ST_SEND_REQ : ST_WAIT_REQ;  // roles swap
        end
      end
      ST_WAIT_REQ: begin
        if (rxValid && rxKind == MSG_REQ) begin
          if (stat.reqOk) begin
            stb.loadFilt = 1'b1;
            stateD = ST_SEND_CONF;
          end else begin
            stateD = ST_ERROR;
          end
        end else if (rxValid && rxKind == MSG_ACK) begin
          stateD = ST_PHASE_SWITCH;
        end else if (stat.waitExpired) begin
          stateD = ST_ERROR;
        end else begin
          stb.incWait = 1'b1;
        end
      end
      ST_SEND_CONF: begin
        stb.sendConf = 1'b1;
        stb.clrWait  = 1'b1;
        stateD = ST_WAIT_REQ;
      end
      ST_DONE: begin
        stb.setDone = 1'b1;
        stateD = ST_IDLE;
      end
      ST_ERROR: begin
        stb.setErr = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end
endmodule

// File: rtl/lnkeq_hs_ctrl.sv
module lnkeq_hs_ctrl
  import lnkeq_pkg::*;
#(
  parameter int ITER_W     = 8,
  parameter int TMO_W      = 16,
  parameter int MAX_PRESET = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              isRoot,
  input  logic [ITER_W-1:0] cfgIters,
  input  logic [TMO_W-1:0]  cfgTimeout,
  input  logic [7:0]        cfgFullSwing,
  input  logic              locUsePreset,
  input  logic [3:0]        locPreset,
  input  logic [5:0]        locPre,
  input  logic [5:0]        locMain,
  input  logic [5:0]        locPost,
  input  logic              rxValid,
  input  logic [1:0]        rxKind,
  input  logic              rxUsePreset,
  input  logic [3:0]        rxPreset,
  input  logic [5:0]        rxPre,
  input  logic [5:0]        rxMain,
  input  logic [5:0]        rxPost,
  output logic              txValid,
  output logic [1:0]        txKind,
  output logic              txUsePreset,
  output logic [3:0]        txPreset,
  output logic [5:0]        txPre,
  output logic [5:0]        txMain,
  output logic [5:0]        txPost,
  output logic              tuneStart,
  input  logic              tuneDone,
  output logic              filtUsePreset,
  output logic [3:0]        filtPreset,
  output logic [5:0]        filtPre,
  output logic [5:0]        filtMain,
  output logic [5:0]        filtPost,
  output logic              eqDone,
  output logic              eqError
);
  ctrlStb_t stb;
  dpStat_t  stat;
  eqSet_t   locSet, rxSet, txSet, filtSet;

  assign locSet = {locUsePreset, locPreset, locPre, locMain, locPost};
  assign rxSet  = {rxUsePreset, rxPreset, rxPre, rxMain, rxPost};
  assign {txUsePreset, txPreset, txPre, txMain, txPost} = txSet;
  assign {filtUsePreset, filtPreset, filtPre, filtMain, filtPost} = filtSet;

  lnkeq_ctrl ctrl_i (
    .clk(clk), .rst(rst), .start(start), .isRoot(isRoot),
    .rxValid(rxValid), .rxKind(rxKind), .tuneDone(tuneDone),
    .stat(stat), .stb(stb)
  );

  lnkeq_datapath #(.ITER_W(ITER_W), .TMO_W(TMO_W), .MAX_PRESET(MAX_PRESET)) dp_i (
    .clk(clk), .rst(rst), .stb(stb),
    .cfgIters(cfgIters), .cfgTimeout(cfgTimeout), .cfgFullSwing(cfgFullSwing),
    .locSet(locSet), .rxSet(rxSet), .stat(stat),
    .txValid(txValid), .txKind(txKind), .txSet(txSet), .tuneStart(tuneStart),
    .filtSet(filtSet), .eqDone(eqDone), .eqError(eqError)
  );
endmodule

// File: rtl/lnkeq_hs_chk.sv
module lnkeq_hs_chk (
  input logic       clk,
  input logic       rst,
  input logic       rxValid,
  input logic [1:0] rxKind,
  input logic [5:0] rxPre,
  input logic [5:0] rxMain,
  input logic [5:0] rxPost,
  input logic       txValid,
  input logic [1:0] txKind,
  input logic [5:0] txPre,
  input logic [5:0] txMain,
  input logic [5:0] txPost,
  input logic       tuneStart,
  input logic [5:0] filtPre,
  input logic [5:0] filtMain,
  input logic [5:0] filtPost,
  input logic       eqDone,
  input logic       eqError
);
  a_r3_kind_legal: assert property (@(posedge clk) disable iff (rst)
    txValid |-> txKind != 2'd0)
    else $error("a_r3_kind_legal");

  a_r4_conf_echoes_req: assert property (@(posedge clk) disable iff (rst)
    (txValid && txKind == 2'd2) |->
      ($past(rxValid, 2) && $past(rxKind, 2) == 2'd1 && txPre == $past(rxPre, 2)
       && txMain == $past(rxMain, 2) && txPost == $past(rxPost, 2)))
    else $error("a_r4_conf_echoes_req");

  a_r5_tune_after_conf: assert property (@(posedge clk) disable iff (rst)
    tuneStart |-> $past(rxValid && rxKind == 2'd2))
    else $error("a_r5_tune_after_conf");

  a_r5_tune_single: assert property (@(posedge clk) disable iff (rst)
    tuneStart |=> !tuneStart)
    else $error("a_r5_tune_single");

  a_r8_filt_only_on_req: assert property (@(posedge clk) disable iff (rst)
    !($stable(filtPre) && $stable(filtMain) && $stable(filtPost))
      |-> $past(rxValid && rxKind == 2'd1))
    else $error("a_r8_filt_only_on_req");

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(eqDone && eqError))
    else $error("a_r11_flags_exclusive");
endmodule

bind lnkeq_hs_ctrl lnkeq_hs_chk chk_i (
  .clk(clk), .rst(rst), .rxValid(rxValid), .rxKind(rxKind),
  .rxPre(rxPre), .rxMain(rxMain), .rxPost(rxPost),
  .txValid(txValid), .txKind(txKind), .txPre(txPre), .txMain(txMain), .txPost(txPost),
  .tuneStart(tuneStart), .filtPre(filtPre), .filtMain(filtMain), .filtPost(filtPost),
  .eqDone(eqDone), .eqError(eqError)
);

// File: tb/lnkeq_hs_ctrl_tb_top.sv
module lnkeq_hs_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_REQ = 2'd1, K_CONF = 2'd2, K_ACK = 2'd3;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, isRoot = 1'b0, tuneDone = 1'b0;
  logic [7:0]  cfgIters = 8'd2, cfgFullSwing = 8'd24;
  logic [15:0] cfgTimeout = 16'd1000;
  logic locUsePreset = 1'b0; logic [3:0] locPreset = '0;
  logic [5:0] locPre = 6'd6, locMain = 6'd16, locPost = 6'd2;
  logic rxValid = 1'b0; logic [1:0] rxKind = '0; logic rxUsePreset = 1'b0;
  logic [3:0] rxPreset = '0; logic [5:0] rxPre = '0, rxMain = '0, rxPost = '0;
  logic txValid, txUsePreset, tuneStart, filtUsePreset, eqDone, eqError;
  logic [1:0] txKind; logic [3:0] txPreset, filtPreset;
  logic [5:0] txPre, txMain, txPost, filtPre, filtMain, filtPost;

  int checks = 0, errors = 0, tuneCount = 0;
  logic [24:0] expQ[$];
  logic [24:0] got, expItem;
  assign got = {txKind, txUsePreset, txPreset, txPre, txMain, txPost};

  always #(CLK_PERIOD/2) clk = ~clk;

  lnkeq_hs_ctrl dut_i (
    .clk(clk), .rst(rst), .start(start), .isRoot(isRoot), .cfgIters(cfgIters),
    .cfgTimeout(cfgTimeout), .cfgFullSwing(cfgFullSwing), .locUsePreset(locUsePreset),
    .locPreset(locPreset), .locPre(locPre), .locMain(locMain), .locPost(locPost),
    .rxValid(rxValid), .rxKind(rxKind), .rxUsePreset(rxUsePreset), .rxPreset(rxPreset),
    .rxPre(rxPre), .rxMain(rxMain), .rxPost(rxPost), .txValid(txValid), .txKind(txKind),
    .txUsePreset(txUsePreset), .txPreset(txPreset), .txPre(txPre), .txMain(txMain),
    .txPost(txPost), .tuneStart(tuneStart), .tuneDone(tuneDone),
    .filtUsePreset(filtUsePreset), .filtPreset(filtPreset), .filtPre(filtPre),
    .filtMain(filtMain), .filtPost(filtPost), .eqDone(eqDone), .eqError(eqError)
  );

  function automatic logic [24:0] mk(input logic [1:0] k, input logic up, input logic [3:0] pr,
                                     input logic [5:0] a, input logic [5:0] b, input logic [5:0] c);
    return {k, up, pr, a, b, c};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every outgoing message is popped and compared
  always @(negedge clk) begin
    if (!rst && txValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2/R3 unexpected message actual=%h expected=none", got);
      end else begin
        expItem = expQ.pop_front();
        if (got !== expItem) begin
          errors++;
          $display("FAIL %s message actual=%h expected=%h",
                   (expItem[24:23] == K_CONF) ? "R4" : "R3/R9", got, expItem);
        end
      end
    end
    if (!rst && tuneStart) tuneCount++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendMsg(input logic [24:0] m);
    @(negedge clk);
    {rxKind, rxUsePreset, rxPreset, rxPre, rxMain, rxPost} = m;
    rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
    rxKind  = '0;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitQ(input string tag);
    int n = 0;
    while (expQ.size() != 0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(expQ.size() == 0, tag, expQ.size(), 0);
  endtask

  task automatic finishTune();
    tick(2);
    tuneDone = 1'b1;
    @(negedge clk);
    tuneDone = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int tc;
    tick(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!txValid && !tuneStart && !eqDone && !eqError, "R1 outputs after reset",
        {txValid, tuneStart, eqDone, eqError}, 0);
    chk({filtUsePreset, filtPreset, filtPre, filtMain, filtPost} == '0, "R1 filter after reset",
        {filtUsePreset, filtPreset, filtPre, filtMain, filtPost}, 0);

    // Scenario A: endpoint, two rounds, then responder in phase 2
    isRoot = 1'b0; cfgIters = 8'd2;
    expQ.push_back(mk(K_REQ, 0, 0, 6, 16, 2));
    pulseStart();
    for (int i = 0; i < 2; i++) begin
      waitQ("R2 endpoint requests first");
      tc = tuneCount;
      tick(3);
      chk(tuneCount == tc, "R5 no tuning before confirmation", tuneCount, tc);
      sendMsg(mk(K_CONF, 0, 0, 6, 16, 2));
      chk(tuneStart == 1'b1, "R5 tuneStart after matching confirmation", tuneStart, 1);
      if (i == 0) expQ.push_back(mk(K_REQ, 0, 0, 6, 16, 2));
      else        expQ.push_back(mk(K_ACK, 0, 0, 0, 0, 0));
      finishTune();
    end
    waitQ("R9 final acknowledge after two rounds");
    tick(2);
    expQ.push_back(mk(K_CONF, 0, 0, 6, 16, 2));
    sendMsg(mk(K_REQ, 0, 0, 6, 16, 2));
    waitQ("R10 responder in phase 2");
    chk({filtPre, filtMain, filtPost} == {6'd6, 6'd16, 6'd2}, "R4 filter loaded 6/16/2",
        {filtPre, filtMain, filtPost}, {6'd6, 6'd16, 6'd2});
    expQ.push_back(mk(K_CONF, 0, 0, 5, 15, 4));
    sendMsg(mk(K_REQ, 0, 0, 5, 15, 4));
    waitQ("R4 second confirmation");
    chk({filtPre, filtMain, filtPost} == {6'd5, 6'd15, 6'd4}, "R4 filter loaded 5/15/4",
        {filtPre, filtMain, filtPost}, {6'd5, 6'd15, 6'd4});
    sendMsg(mk(K_ACK, 0, 0, 0, 0, 0));
    tick(4);
    chk(eqDone && !eqError, "R10 done after phase 2", {eqDone, eqError}, 2'b10);

    // Scenario B: root, cfgIters=0 counts as one round, preset form
    isRoot = 1'b1; cfgIters = 8'd0;
    locUsePreset = 1'b1; locPreset = 4'd4; locPre = 0; locMain = 0; locPost = 0;
    pulseStart();
    tick(5);
    chk(!txValid && !eqDone, "R2 root silent in phase 1, R11 done cleared", {txValid, eqDone}, 0);
    expQ.push_back(mk(K_CONF, 1, 7, 0, 0, 0));
    sendMsg(mk(K_REQ, 1, 7, 0, 0, 0));
    waitQ("R4 preset confirmation");
    chk(filtUsePreset && filtPreset == 4'd7, "R4 preset applied",
        {filtUsePreset, filtPreset}, {1'b1, 4'd7});
    expQ.push_back(mk(K_REQ, 1, 4, 0, 0, 0));
    sendMsg(mk(K_ACK, 0, 0, 0, 0, 0));
    waitQ("R2 root requests in phase 2");
    sendMsg(mk(K_CONF, 1, 4, 0, 0, 0));
    chk(tuneStart == 1'b1, "R5 root tunes after confirmation", tuneStart, 1);
    expQ.push_back(mk(K_ACK, 0, 0, 0, 0, 0));
    finishTune();
    waitQ("R9 single round when cfgIters is 0");
    tick(3);
    chk(eqDone == 1'b1, "R10 root done", eqDone, 1);

    // Scenario C: mismatching confirmation
    isRoot = 1'b0; cfgIters = 8'd2;
    locUsePreset = 1'b0; locPreset = 0; locPre = 6; locMain = 16; locPost = 2;
    expQ.push_back(mk(K_REQ, 0, 0, 6, 16, 2));
    pulseStart();
    waitQ("R3 request content");
    chk(!eqDone, "R11 start clears done", eqDone, 0);
    tc = tuneCount;
    sendMsg(mk(K_CONF, 0, 0, 6, 16, 3));
    chk(tuneStart == 1'b0, "R6 no tuneStart on bad echo", tuneStart, 0);
    tick(3);
    chk(eqError && tuneCount == tc, "R6 error on mismatch", {eqError, tuneCount[7:0]}, {1'b1, tc[7:0]});

    // Scenario D: timeout boundary
    cfgTimeout = 16'd20;
    expQ.push_back(mk(K_REQ, 0, 0, 6, 16, 2));
    pulseStart();
    waitQ("R7 request before timeout");
    chk(!eqError, "R11 start clears error", eqError, 0);
    tick(17);
    chk(!eqError, "R7 no error before limit", eqError, 0);
    tick(7);
    chk(eqError, "R7 error after limit", eqError, 1);
    cfgTimeout = 16'd1000;

    // Scenario E: invalid requests and the full-swing boundary
    isRoot = 1'b1;
    pulseStart();
    sendMsg(mk(K_REQ, 0, 0, 10, 10, 10));
    tick(3);
    chk(eqError, "R8 sum above full swing rejected", eqError, 1);
    chk(filtUsePreset && filtPreset == 4'd7 && filtPre == 0, "R8 filter unchanged",
        {filtUsePreset, filtPreset, filtPre}, {1'b1, 4'd7, 6'd0});
    pulseStart();
    expQ.push_back(mk(K_CONF, 0, 0, 8, 8, 8));
    sendMsg(mk(K_REQ, 0, 0, 8, 8, 8));
    waitQ("R8 sum equal to full swing accepted");
    chk(!eqError && filtPre == 6'd8 && filtPost == 6'd8, "R8 boundary applied",
        {eqError, filtPre, filtPost}, {1'b0, 6'd8, 6'd8});
    sendMsg(mk(K_REQ, 1, 11, 0, 0, 0));
    tick(3);
    chk(eqError && !filtUsePreset && filtMain == 6'd8, "R8 preset above 10 rejected",
        {eqError, filtUsePreset, filtMain}, {1'b1, 1'b0, 6'd8});
    chk(expQ.size() == 0, "R8 no confirmation for invalid", expQ.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule